// File: doc/BRIEF.md
# DMA Stall Signature Detector

This block decides whether a transmit DMA engine has locked up in one of two known deadlock patterns. It watches four 32-bit debug status words (called words 3, 4, 5 and 6 here) that the DMA logic exports. When a check is requested, it first confirms that the words are frozen. It then tests the frozen state against two stall signatures.

A check begins when `check_req` is seen high while `enable` is high and no check is running. The block takes a snapshot of the four words. It then compares the live words with the snapshot on each of the next 50 clocks. Any difference ends the check at once with the result "none". If all 50 comparisons agree, the snapshot is matched against signature 1 and then signature 2. A frozen state that matches neither gives "unknown". When a check ends, `done` pulses for one cycle and the result code is presented.

Top module: `dma_stall_sig_detect`

## Requirements
- R1: After reset, `result` is 0 and `done` is 0.
- R2: A request is accepted when `check_req` and `enable` are both high and no check is running. On acceptance, `result` is cleared to 0 (none) by the following cycle.
- R3: If all four words stay unchanged, `done` rises 50 clock edges after the accepting edge. That is one live-to-snapshot comparison per clock.
- R4: A change in any bit of any of the four words, seen at a comparison edge, ends the check at that edge. `done` is then high in the next cycle with `result` 0.
- R5: Signature 1 requires two conditions. The value 6 must appear in any 5-bit slot of word 4 (slot i at bits 5i+4..5i, i = 0..5) or of word 5 (i = 0..3). Bits 1..0 of word 6 must also equal 1. It reports `result` 1.
- R6: Signature 2 requires word 3 bits 21..18 = 9, bits 25..22 = 8 and bits 28..26 = 4. It reports `result` 2.
- R7: A signature matches only if all of its conditions hold. A frozen state that matches neither signature reports `result` 3 (unknown).
- R8: When both signatures match, `result` is 1.
- R9: While `enable` is low, requests are ignored. If `enable` drops during a check, the check is abandoned without a `done` pulse and `result` stays 0.
- R10: A request that arrives while a check is running has no effect on that check's timing or result.
- R11: `done` is a single-cycle pulse. `result` holds its value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows checks to start and to continue |
| check_req | input | 1 | Request to start a check |
| dbg_w3 | input | 32 | Debug word 3 (queue state fields) |
| dbg_w4 | input | 32 | Debug word 4 (six chain-state slots) |
| dbg_w5 | input | 32 | Debug word 5 (four chain-state slots) |
| dbg_w6 | input | 32 | Debug word 6 (completion state in bits 1..0) |
| result | output | 2 | 0 none, 1 signature 1, 2 signature 2, 3 unknown |
| done | output | 1 | One-cycle pulse when a check ends |

## Verification
The embedded assertions check several properties on every cycle. A differing sample must give "none" on the next cycle. Signature 1 must win when both signatures match. Dropping `enable` during a check must suppress `done`. `done` must be a single pulse. `result` must hold while the block is idle. They also check that the comparison counter stays inside its window and that the snapshot captures the live words.

Some behaviours can only be shown by the bench's scenarios:
- the exact 50-edge latency;
- the slot search over every slot position of words 4 and 5;
- every subset of the signature-2 fields;
- mismatches injected at the first, a middle and the last comparison;
- ignored requests.

// File: rtl/stall_sig_pkg.sv
// Package: shared result codes, controller states and signature field
// positions for the DMA stall signature detector.
package stall_sig_pkg;

    // Result code presented on the result port.
    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_SIG1    = 2'd1,
        RES_SIG2    = 2'd2,
        RES_UNKNOWN = 2'd3
    } stall_res_e;

    // Controller state.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WATCH = 1'b1
    } stall_state_e;

    // Signature 1: chain-state slot search and completion field.
    localparam int SLOT_W        = 5;
    localparam int W4_SLOTS      = 6;
    localparam int W5_SLOTS      = 4;
    localparam int CHAIN_TARGET  = 6;
    localparam int CMPL_W        = 2;
    localparam int CMPL_TARGET   = 1;

    // Signature 2: three packed fields of word 3.
    localparam int STITCH_LSB    = 18;
    localparam int STITCH_W      = 4;
    localparam int STITCH_TARGET = 9;
    localparam int FETCH_LSB     = 22;
    localparam int FETCH_W       = 4;
    localparam int FETCH_TARGET  = 8;
    localparam int QDONE_LSB     = 26;
    localparam int QDONE_W       = 3;
    localparam int QDONE_TARGET  = 4;

endpackage

// File: rtl/stall_slot_scan.sv
// Module: stall_slot_scan
// Reports whether any of NUM_SLOTS adjacent SLOT_W-bit slots of a word
// (slot i at bit i*SLOT_W) holds TARGET. Purely combinational.
// Assumes NUM_SLOTS*SLOT_W <= WORD_W.
module stall_slot_scan #(
    parameter int WORD_W    = 32,
    parameter int SLOT_W    = 5,
    parameter int NUM_SLOTS = 6,
    parameter int TARGET    = 6
) (
    input  logic [WORD_W-1:0] word,
    output logic              hit
);
    logic [NUM_SLOTS-1:0] slot_hit;

    // One equality comparator per slot.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign slot_hit[i] = (word[i*SLOT_W +: SLOT_W] == SLOT_W'(TARGET));
    end

    // Any slot matching counts as a hit.
    assign hit = |slot_hit;
endmodule

// File: rtl/stall_sig_matcher.sv
// Module: stall_sig_matcher
// Evaluates both stall signatures on a snapshot of the four debug words.
// Purely combinational; priority between the two is left to the caller.
module stall_sig_matcher
    import stall_sig_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] w3,
    input  logic [WORD_W-1:0] w4,
    input  logic [WORD_W-1:0] w5,
    input  logic [WORD_W-1:0] w6,
    output logic              sig1_hit,
    output logic              sig2_hit
);
    logic chain_in_w4;
    logic chain_in_w5;
    logic cmpl_ok;
    logic stitch_ok;
    logic fetch_ok;
    logic qdone_ok;

    stall_slot_scan #(
        .WORD_W(WORD_W), .SLOT_W(SLOT_W), .NUM_SLOTS(W4_SLOTS), .TARGET(CHAIN_TARGET)
    ) u_scan_w4 (
        .word(w4),
        .hit (chain_in_w4)
    );

    stall_slot_scan #(
        .WORD_W(WORD_W), .SLOT_W(SLOT_W), .NUM_SLOTS(W5_SLOTS), .TARGET(CHAIN_TARGET)
    ) u_scan_w5 (
        .word(w5),
        .hit (chain_in_w5)
    );

    // Field comparisons for both signatures.
    always_comb begin
        cmpl_ok   = (w6[CMPL_W-1:0] == CMPL_W'(CMPL_TARGET));
        stitch_ok = (w3[STITCH_LSB +: STITCH_W] == STITCH_W'(STITCH_TARGET));
        fetch_ok  = (w3[FETCH_LSB  +: FETCH_W]  == FETCH_W'(FETCH_TARGET));
        qdone_ok  = (w3[QDONE_LSB  +: QDONE_W]  == QDONE_W'(QDONE_TARGET));
    end

    // A signature needs every one of its conditions.
    assign sig1_hit = (chain_in_w4 | chain_in_w5) & cmpl_ok;
    assign sig2_hit = stitch_ok & fetch_ok & qdone_ok;
endmodule

// File: rtl/stall_capture_regs.sv
// Module: stall_capture_regs
// Holds a snapshot of NUM_WORDS live words, taken when load is high, and
// reports whether the live words still equal the snapshot.
// Assumes the caller asserts load for exactly the capture cycle.
module stall_capture_regs #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]   live,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]   held,
    output logic                               same
);
    logic [NUM_WORDS-1:0] word_same;

    // Snapshot register, loaded on request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (load) begin
            held <= live;
        end
    end

    // Per-word equality against the snapshot.
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_cmp
        assign word_same[i] = (live[i] == held[i]);
    end

    // All words must agree.
    assign same = &word_same;

    // R3: the snapshot reflects the live words of the capture cycle.
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (held == $past(live)));
endmodule

// File: rtl/dma_stall_sig_detect.sv
// Module: dma_stall_sig_detect
// Top of the DMA stall signature detector. On an accepted request it takes a
// snapshot of four debug words. It then checks that the words stay frozen for
// NUM_RESAMPLES clocks. Finally it reports which stall signature, if any, the
// frozen state matches, with signature 1 taking priority.
// Assumes the debug words are synchronous to clk.
module dma_stall_sig_detect
    import stall_sig_pkg::*;
#(
    parameter int WORD_W        = 32,
    parameter int NUM_RESAMPLES = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              check_req,
    input  logic [WORD_W-1:0] dbg_w3,
    input  logic [WORD_W-1:0] dbg_w4,
    input  logic [WORD_W-1:0] dbg_w5,
    input  logic [WORD_W-1:0] dbg_w6,
    output logic [1:0]        result,
    output logic              done
);
    localparam int NUM_WORDS = 4;
    localparam int CNT_W     = (NUM_RESAMPLES > 1) ? $clog2(NUM_RESAMPLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_RESAMPLES - 1);

    stall_state_e                     state;
    logic [CNT_W-1:0]                 cnt;
    stall_res_e                       result_q;
    logic                             done_q;
    logic                             accept;
    logic                             same;
    logic                             last;
    logic                             sig1_hit;
    logic                             sig2_hit;
    logic [NUM_WORDS-1:0][WORD_W-1:0] live;
    logic [NUM_WORDS-1:0][WORD_W-1:0] held;

    assign live   = {dbg_w6, dbg_w5, dbg_w4, dbg_w3};
    assign accept = (state == ST_IDLE) && enable && check_req;
    assign last   = (cnt == LAST_CNT);

    stall_capture_regs #(
        .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)
    ) u_capture (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .live (live),
        .held (held),
        .same (same)
    );

    stall_sig_matcher #(
        .WORD_W(WORD_W)
    ) u_match (
        .w3      (held[0]),
        .w4      (held[1]),
        .w5      (held[2]),
        .w6      (held[3]),
        .sig1_hit(sig1_hit),
        .sig2_hit(sig2_hit)
    );

    // Check sequencer: capture, stability window, then priority decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            result_q <= RES_NONE;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_WATCH;
                        cnt      <= '0;
                        result_q <= RES_NONE;
                    end
                end
                ST_WATCH: begin
                    if (!enable) begin
                        state <= ST_IDLE;
                    end else if (!same) begin
                        state    <= ST_IDLE;
                        result_q <= RES_NONE;
                        done_q   <= 1'b1;
                    end else if (last) begin
                        state    <= ST_IDLE;
                        done_q   <= 1'b1;
                        if (sig1_hit)      result_q <= RES_SIG1;
                        else if (sig2_hit) result_q <= RES_SIG2;
                        else               result_q <= RES_UNKNOWN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign result = result_q;
    assign done   = done_q;

    // R11: done lasts a single cycle.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: result holds while idle and no request is accepted.
    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !accept) |=> $stable(result));

    // R4: a differing sample ends the check with none.
    assert_mismatch_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && enable && !same) |=> (done && result == 2'd0));

    // R8: signature 1 wins over signature 2.
    assert_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && enable && same && last && sig1_hit)
        |=> (done && result == 2'd1));

    // R9: dropping enable during a check suppresses done.
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && !enable) |=> !done);

    // R3: the comparison counter stays inside its window.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_CNT);
endmodule

// File: tb/dma_stall_sig_detect_tb.sv
module dma_stall_sig_detect_tb;
    localparam int NRS = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        check_req = 1'b0;
    logic [31:0] w3 = '0, w4 = '0, w5 = '0, w6 = '0;
    logic [1:0]  result;
    logic        done;

    int checks = 0;
    int fails = 0;
    int wd = 0;

    always #2.5 clk = ~clk;

    dma_stall_sig_detect #(.WORD_W(32), .NUM_RESAMPLES(NRS)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .check_req(check_req),
        .dbg_w3(w3), .dbg_w4(w4), .dbg_w5(w5), .dbg_w6(w6),
        .result(result), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected code computed from R5..R8.
    function automatic int exp_code(input logic [31:0] a3, a4, a5, a6);
        bit s1 = 0;
        bit s2;
        for (int i = 0; i < 6; i++) if (((a4 >> (5*i)) & 32'h1f) == 6) s1 = 1;
        for (int i = 0; i < 4; i++) if (((a5 >> (5*i)) & 32'h1f) == 6) s1 = 1;
        s1 = s1 && ((a6 & 3) == 1);
        s2 = (((a3 >> 18) & 15) == 9) && (((a3 >> 22) & 15) == 8) && (((a3 >> 26) & 7) == 4);
        return s1 ? 1 : (s2 ? 2 : 3);
    endfunction

    // Run one check; chg_at >= 0 flips a bit of word chg_word at that cycle.
    task automatic run_check(input logic [31:0] a3, a4, a5, a6, input int chg_at,
                             input int chg_word, input bit extra_req, input string tag);
        int cyc = 0;
        int lat = -1;
        int ecode = (chg_at >= 0) ? 0 : exp_code(a3, a4, a5, a6);
        int elat = (chg_at >= 0) ? chg_at + 1 : NRS;
        @(negedge clk);
        w3 = a3; w4 = a4; w5 = a5; w6 = a6;
        check_req = 1'b1;
        @(negedge clk);
        check_req = 1'b0;
        chk(result == 2'd0, "R2 clear on accept", result, 0);
        while (lat < 0 && cyc < 200) begin
            if (cyc == chg_at) begin
                case (chg_word)
                    0: w3 = w3 ^ 32'h0001_0000;
                    1: w4 = w4 ^ 32'h2000_0000;
                    2: w5 = w5 ^ 32'h0000_0001;
                    default: w6 = w6 ^ 32'h8000_0000;
                endcase
            end
            check_req = (extra_req && (cyc == 20 || cyc == 21)) ? 1'b1 : 1'b0;
            @(negedge clk);
            cyc++;
            if (done) lat = cyc;
        end
        check_req = 1'b0;
        chk(lat == elat, {tag, " R3/R4 latency"}, lat, elat);
        chk(result == 2'(ecode), {tag, " result"}, result, ecode);
        @(negedge clk);
        chk(!done, "R11 done single pulse", done, 0);
        chk(result == 2'(ecode), "R11 result hold", result, ecode);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(result == 2'd0, "R1 reset result", result, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);

        // R5/R7: chain state in each slot of words 4 and 5, all completion values.
        for (int s = 0; s < 10; s++) begin
            for (int c = 0; c < 4; c++) begin
                logic [31:0] a4 = (s < 6) ? (32'd6 << (5*s)) : 32'h0;
                logic [31:0] a5 = (s >= 6) ? (32'd6 << (5*(s-6))) : 32'h0;
                run_check(32'h0, a4, a5, 32'hABCD_0000 | 32'(c), -1, 0, 0, "R5 slot sweep");
            end
        end
        // R5: value 6 misaligned to a slot does not count.
        run_check(32'h0, 32'd6 << 2, 32'd6 << 21, 32'h1, -1, 0, 0, "R5 misaligned");

        // R6/R7: every subset of the three signature-2 fields.
        for (int m = 0; m < 8; m++) begin
            logic [31:0] a3 = 32'h0;
            if (m[0]) a3 |= 32'd9 << 18;
            if (m[1]) a3 |= 32'd8 << 22;
            if (m[2]) a3 |= 32'd4 << 26;
            run_check(a3 | 32'hE000_0003, 32'h0, 32'h0, 32'h0, -1, 0, 0, "R6 field subsets");
        end

        // R8: both signatures match.
        run_check((32'd9 << 18) | (32'd8 << 22) | (32'd4 << 26), 32'd6 << 25, 32'h0, 32'h1,
                  -1, 0, 0, "R8 priority");

        // R4: mismatch on each word at the first, middle and last comparison.
        for (int w = 0; w < 4; w++) begin
            run_check(32'd9 << 18, 32'd6, 32'h0, 32'h1, 0, w, 0, "R4 mismatch first");
            run_check(32'd9 << 18, 32'd6, 32'h0, 32'h1, 17, w, 0, "R4 mismatch middle");
            run_check(32'd9 << 18, 32'd6, 32'h0, 32'h1, NRS - 1, w, 0, "R4 mismatch last");
        end

        // R10: extra request during a running check.
        run_check(32'h0, 32'd6 << 10, 32'h0, 32'h1, -1, 0, 1, "R10 busy request");

        // R9: requests ignored while disabled; result keeps previous value 1.
        begin
            bit seen = 0;
            @(negedge clk);
            enable = 1'b0;
            check_req = 1'b1;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (done) seen = 1;
            end
            check_req = 1'b0;
            chk(!seen, "R9 disabled no done", seen, 0);
            chk(result == 2'd1, "R9 disabled result kept", result, 1);
        end

        // R9: enable dropped mid-check abandons it without done.
        begin
            bit seen = 0;
            enable = 1'b1;
            w4 = 32'd6; w6 = 32'h1;
            check_req = 1'b1;
            @(negedge clk);
            check_req = 1'b0;
            repeat (10) @(negedge clk);
            enable = 1'b0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (done) seen = 1;
            end
            chk(!seen, "R9 abort no done", seen, 0);
            chk(result == 2'd0, "R9 abort result none", result, 0);
            enable = 1'b1;
        end

        // R3: a normal check still works after the abort.
        run_check(32'h0, 32'h0, 32'd6 << 15, 32'h1, -1, 0, 0, "R3 after abort");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule